// File: doc/BRIEF.md
# Nine-Bit Multidrop Serial Receiver with Address Filtering

This block receives asynchronous serial frames that carry nine data bits. The ninth bit, bit 8, tells the two kinds of frame apart. When bit 8 is 1 the frame names a node address. When bit 8 is 0 the frame carries payload. The RX line passes through a synchronizer and is sampled sixteen times per bit, and each bit value is decided near mid-bit by a vote of three samples. The bits are gathered in a shift register. When the stop bit ends, the block decides whether the frame goes into a single-entry holding buffer and whether the receive flag is raised.

The host drives a filter enable. While the enable is high, only address frames get through, so a node waiting for its address sees no payload traffic. Once the node recognises its own address, the host lowers the enable and the following payload frames are delivered. A read strobe frees the buffer and clears the flag and the two error flags. A frame whose stop bit reads low raises a framing-error flag. A frame that is accepted while the buffer is still unread is dropped, and the overrun flag is raised. The baud rate comes from a parameterised clock divider that produces the 16x sampling tick.

Top module: `uart9_addr_rx`

## Requirements
- R1: A frame is one low start bit, then nine data bits with bit 0 sent first, then a stop bit. The buffered frame appears as bits 7..0 on `rx_data_o` and bit 8 on `rx_bit8_o`.
- R2: While `addr_filt_en_i` is 0, every completed frame is loaded and `rx_flag_o` goes to 1, for either value of bit 8.
- R3: While `addr_filt_en_i` is 1, a frame with bit 8 = 1 is loaded and `rx_flag_o` goes to 1.
- R4: While `addr_filt_en_i` is 1, a frame with bit 8 = 0 is discarded. `rx_data_o`, `rx_bit8_o` and `rx_flag_o` keep their values.
- R5: After an address frame, payload frames are still discarded as long as the enable stays 1. After the host clears the enable, payload frames are loaded.
- R6: A one-cycle `rd_i` pulse clears `rx_flag_o`, `frame_err_o` and `overrun_o` on the next clock, unless a frame completes in that same cycle.
- R7: If a frame that would be loaded completes while `rx_flag_o` is 1, the frame is dropped, `overrun_o` goes to 1 and the buffer keeps its old contents.
- R8: A stop bit that reads low sets `frame_err_o`. The frame is still loaded or discarded by the same rules as any other frame.
- R9: A low pulse on the line shorter than half a bit does not start a frame. The next valid frame is received correctly.
- R10: The filter enable is sampled when the frame is transferred, so a change made during a frame decides that frame's fate.
- R11: After reset, `rx_flag_o`, `frame_err_o` and `overrun_o` are 0, and `rx_data_o` and `rx_bit8_o` are 0.
- R12: The load and the rise of `rx_flag_o` happen at the end of the stop bit, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| addr_filt_en_i | input | 1 | 1: pass only frames with bit 8 = 1 |
| rd_i | input | 1 | Host read strobe; frees the buffer and clears the flags |
| rx_data_o | output | 8 | Buffered frame bits 7..0 |
| rx_bit8_o | output | 1 | Buffered frame bit 8 |
| rx_flag_o | output | 1 | Buffer holds an unread frame |
| frame_err_o | output | 1 | A stop bit read low since the last read |
| overrun_o | output | 1 | An accepted frame was dropped because the buffer was full |

## Verification
The hardest case to reach is a change of the filter enable while a frame is in flight. Acceptance depends on the enable's value at the end of the stop bit, not at the start bit, so the bench must move the enable partway through a frame. It does this by forking the frame sender with a timed write to the enable, once in each direction. Overrun is reached by sending two accepted frames back to back with no read between them. The false-start case is reached by pulling the line low for a few clocks, well short of mid-bit.

// File: rtl/uart9_rx_pkg.sv
package uart9_rx_pkg;
    localparam int OVS        = 16;
    localparam int OVS_W      = $clog2(OVS);
    localparam int FRAME_BITS = 9;
    localparam int NBIT_W     = $clog2(FRAME_BITS);
    localparam int DECIDE_AT  = OVS / 2 + 1;
    localparam int VOTES      = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        rx_state_e               st;
        logic [OVS_W-1:0]        cnt;
        logic [NBIT_W-1:0]       nbit;
        logic [FRAME_BITS-1:0]   shreg;
        logic                    stop_ok;
        logic                    done;
    } frame_regs_t;

    typedef struct packed {
        logic [FRAME_BITS-1:0]   word;
        logic                    full;
        logic                    ferr;
        logic                    ovr;
    } hold_regs_t;
endpackage

// File: rtl/uart9_tick_gen.sv
module uart9_tick_gen #(
    parameter int CLKS_PER_TICK = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int LIMIT = CLKS_PER_TICK - 1;
    localparam int CNT_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (cnt_q == CNT_W'(LIMIT)) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = (cnt_q == CNT_W'(LIMIT));

    assert_div_in_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(LIMIT));
endmodule

// File: rtl/uart9_line_sampler.sv
module uart9_line_sampler
    import uart9_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rx_i,
    output logic line_o,
    output logic vote_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTES-1:0]       hist;
    } samp_regs_t;

    samp_regs_t d, q;

    always_comb begin
        d = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], rx_i};
        if (tick_i) d.hist = {q.hist[VOTES-2:0], q.sync[SYNC_STAGES-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign line_o = q.sync[SYNC_STAGES-1];
    assign vote_o = ($countones(q.hist) >= 2);
endmodule

// File: rtl/uart9_frame_fsm.sv
module uart9_frame_fsm
    import uart9_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_i,
    input  logic                  line_i,
    input  logic                  vote_i,
    output logic                  done_o,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  stop_ok_o
);
    localparam logic [OVS_W-1:0]  CNT_LAST   = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0]  CNT_DECIDE = OVS_W'(DECIDE_AT);
    localparam logic [NBIT_W-1:0] NBIT_LAST  = NBIT_W'(FRAME_BITS - 1);

    frame_regs_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick_i) begin
            if (q.st != ST_IDLE) d.cnt = q.cnt + 1'b1;
            unique case (q.st)
                ST_IDLE: begin
                    if (!line_i) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (q.cnt == CNT_DECIDE && vote_i) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == CNT_LAST) begin
                        d.st   = ST_DATA;
                        d.cnt  = '0;
                        d.nbit = '0;
                    end
                end
                ST_DATA: begin
                    if (q.cnt == CNT_DECIDE) d.shreg = {vote_i, q.shreg[FRAME_BITS-1:1]};
                    if (q.cnt == CNT_LAST) begin
                        d.cnt = '0;
                        if (q.nbit == NBIT_LAST) d.st = ST_STOP;
                        else                     d.nbit = q.nbit + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (q.cnt == CNT_DECIDE) d.stop_ok = vote_i;
                    if (q.cnt == CNT_LAST) begin
                        d.st   = ST_IDLE;
                        d.cnt  = '0;
                        d.done = 1'b1;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cnt: '0, nbit: '0, shreg: '0, stop_ok: 1'b1, done: 1'b0};
        else        q <= d;
    end

    assign done_o    = q.done;
    assign word_o    = q.shreg;
    assign stop_ok_o = q.stop_ok;

    assert_nbit_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q.nbit <= NBIT_LAST);
    assert_done_from_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q.st) == ST_STOP);
endmodule

// File: rtl/uart9_rx_hold.sv
module uart9_rx_hold
    import uart9_rx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  done_i,
    input  logic [FRAME_BITS-1:0] word_i,
    input  logic                  stop_ok_i,
    input  logic                  filt_en_i,
    input  logic                  rd_i,
    output logic [FRAME_BITS-1:0] word_o,
    output logic                  full_o,
    output logic                  ferr_o,
    output logic                  ovr_o
);
    hold_regs_t d, q;
    logic       accept;

    always_comb begin
        accept = !filt_en_i || word_i[FRAME_BITS-1];
        d      = q;
        if (rd_i) begin
            d.full = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (done_i) begin
            if (!stop_ok_i) d.ferr = 1'b1;
            if (accept) begin
                if (d.full) begin
                    d.ovr = 1'b1;
                end else begin
                    d.word = word_i;
                    d.full = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o = q.word;
    assign full_o = q.full;
    assign ferr_o = q.ferr;
    assign ovr_o  = q.ovr;
endmodule

// File: rtl/uart9_addr_rx.sv
module uart9_addr_rx
    import uart9_rx_pkg::*;
#(
    parameter int CLKS_PER_TICK = 27,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       addr_filt_en_i,
    input  logic       rd_i,
    output logic [7:0] rx_data_o,
    output logic       rx_bit8_o,
    output logic       rx_flag_o,
    output logic       frame_err_o,
    output logic       overrun_o
);
    logic                  tick, line, vote;
    logic                  frm_done, frm_stop_ok;
    logic [FRAME_BITS-1:0] frm_word, buf_word;

    uart9_tick_gen #(.CLKS_PER_TICK(CLKS_PER_TICK)) tick_i (
        .clk(clk), .rst_n(rst_n), .tick_o(tick));

    uart9_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) samp_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_i),
        .line_o(line), .vote_o(vote));

    uart9_frame_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(line), .vote_i(vote),
        .done_o(frm_done), .word_o(frm_word), .stop_ok_o(frm_stop_ok));

    uart9_rx_hold hold_i (
        .clk(clk), .rst_n(rst_n), .done_i(frm_done), .word_i(frm_word),
        .stop_ok_i(frm_stop_ok), .filt_en_i(addr_filt_en_i), .rd_i(rd_i),
        .word_o(buf_word), .full_o(rx_flag_o), .ferr_o(frame_err_o), .ovr_o(overrun_o));

    assign rx_data_o = buf_word[7:0];
    assign rx_bit8_o = buf_word[FRAME_BITS-1];

    assert_flag_needs_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag_o) |-> $past(frm_done));
    assert_filter_drops_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && addr_filt_en_i && !frm_word[FRAME_BITS-1])
        |=> ($stable(rx_data_o) && $stable(rx_bit8_o) && !$rose(rx_flag_o)));
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !frm_done) |=> (!rx_flag_o && !overrun_o && !frame_err_o));
    assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && (!addr_filt_en_i || frm_word[FRAME_BITS-1]) && rx_flag_o && !rd_i)
        |=> (overrun_o && $stable(rx_data_o) && $stable(rx_bit8_o)));
    assert_stop_low_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_stop_ok) |=> frame_err_o);
endmodule

// File: tb/uart9_addr_rx_tb.sv
module uart9_addr_rx_tb_top;
    localparam int C    = 1;
    localparam int BITC = 16 * C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       filt = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] data;
    logic       bit8, flag, ferr, ovr;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    uart9_addr_rx #(.CLKS_PER_TICK(C)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .addr_filt_en_i(filt), .rd_i(rd),
        .rx_data_o(data), .rx_bit8_o(bit8), .rx_flag_o(flag),
        .frame_err_o(ferr), .overrun_o(ovr));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [8:0] w, input logic stop_lvl);
        rx = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 9; i++) begin
            rx = w[i];
            repeat (BITC) @(negedge clk);
        end
        rx = stop_lvl;
        repeat (BITC) @(negedge clk);
        rx = 1'b1;
    endtask

    task automatic settle();
        repeat (24) @(negedge clk);
    endtask

    task automatic host_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [8:0] last;
        logic [8:0] w;
        repeat (4) @(negedge clk);
        // R11 reset state
        check({flag, ferr, ovr, bit8, data} == 12'h0, "R11", {flag, ferr, ovr, bit8, data}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({flag, ferr, ovr, bit8, data} == 12'h0, "R11", {flag, ferr, ovr, bit8, data}, 0);

        // R1 / R2: every nine-bit value with the filter off
        filt = 1'b0;
        for (int v = 0; v < 512; v++) begin
            send(9'(v), 1'b1);
            settle();
            check({flag, bit8, data} == {1'b1, 9'(v)}, "R1_R2", {flag, bit8, data}, {1'b1, 9'(v)});
            host_read();
        end
        last = 9'h1FF;

        // R6: read cleared the flag
        check(flag == 1'b0, "R6", flag, 0);

        // R3 / R4: filter on, alternate bit 8
        filt = 1'b1;
        for (int v = 0; v < 64; v++) begin
            w = {v[0], 8'(v * 37 + 11)};
            send(w, 1'b1);
            settle();
            if (w[8]) begin
                check({flag, bit8, data} == {1'b1, w}, "R3", {flag, bit8, data}, {1'b1, w});
                last = w;
                host_read();
            end else begin
                check({flag, bit8, data} == {1'b0, last}, "R4", {flag, bit8, data}, {1'b0, last});
            end
        end

        // R5: address then payload with filter held, then released
        send(9'h1A5, 1'b1); settle();
        check({flag, bit8, data} == 10'h3A5, "R5", {flag, bit8, data}, 10'h3A5);
        host_read();
        send(9'h033, 1'b1); settle();
        check({flag, bit8, data} == 10'h1A5, "R5", {flag, bit8, data}, 10'h1A5);
        filt = 1'b0;
        send(9'h044, 1'b1); settle();
        check({flag, bit8, data} == 10'h244, "R5", {flag, bit8, data}, 10'h244);

        // R7: second accepted frame without a read
        send(9'h0C3, 1'b1); settle();
        check({ovr, flag, bit8, data} == 11'h644, "R7", {ovr, flag, bit8, data}, 11'h644);
        host_read();
        check({ovr, flag} == 2'b00, "R6", {ovr, flag}, 0);

        // R8: low stop bit, frame still loaded with filter off
        send(9'h15A, 1'b0); settle();
        check({ferr, flag, bit8, data} == 11'h75A, "R8", {ferr, flag, bit8, data}, 11'h75A);
        host_read();
        check(ferr == 1'b0, "R6", ferr, 0);
        filt = 1'b1;
        send(9'h05A, 1'b0); settle();
        check({ferr, flag} == 2'b10, "R8", {ferr, flag}, 2'b10);
        host_read();
        filt = 1'b0;

        // R9: short glitch, then a valid frame
        rx = 1'b0;
        repeat (4) @(negedge clk);
        rx = 1'b1;
        repeat (40) @(negedge clk);
        check(flag == 1'b0, "R9", flag, 0);
        send(9'h0E7, 1'b1); settle();
        check({flag, bit8, data} == 10'h2E7, "R9", {flag, bit8, data}, 10'h2E7);
        host_read();

        // R10: enable changed mid-frame decides the frame
        filt = 1'b1;
        fork
            send(9'h07E, 1'b1);
            begin repeat (5 * BITC) @(negedge clk); filt = 1'b0; end
        join
        settle();
        check({flag, bit8, data} == 10'h27E, "R10", {flag, bit8, data}, 10'h27E);
        host_read();
        fork
            send(9'h081, 1'b1);
            begin repeat (5 * BITC) @(negedge clk); filt = 1'b1; end
        join
        settle();
        check({flag, bit8, data} == 10'h07E, "R10", {flag, bit8, data}, 10'h07E);
        filt = 1'b0;

        // R12: no load before the stop bit has ended
        send(9'h0D2, 1'b1);
        check(flag == 1'b0, "R12", flag, 0);
        repeat (12) @(negedge clk);
        check({flag, bit8, data} == 10'h2D2, "R12", {flag, bit8, data}, 10'h2D2);
        host_read();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule